// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous host and one port of an asynchronous static RAM. A host write request carries an address, a 16-bit word, a two-bit byte skip mask, a flag that picks the memory array or the semaphore space, and the level the host wants on the memory's output-enable pin. The sequencer turns that request into a write cycle with a safe ordering. The address is placed first and held. Then the read/write strobe, the chip or semaphore select and the chosen byte enables all fall in the same clock. Because the select never falls before the strobe, the memory keeps its outputs in high impedance, and the sequencer can drive the data bus from that same clock. At the end of the cycle all enables rise together. Data and address are held for a programmable number of clocks, and then a one-clock done pulse is raised.

Every timing phase is a parameter counted in system clocks. The write pulse is stretched when the memory's output enable is held low during the cycle: it must then cover the memory's output turn-off time plus the data setup time.

The controller has five states. IDLE goes to ADDR_SETUP when a request arrives, or goes straight to DONE when the mask skips both bytes. ADDR_SETUP goes to STROBE when its counter expires. STROBE goes to HOLD when the pulse counter expires. HOLD goes to DONE when the hold counter expires. DONE always returns to IDLE after one clock.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, mem_dq_en_o is 0, and mem_we_n_o, mem_ce_n_o, mem_sem_n_o, mem_ub_n_o and mem_lb_n_o are all 1. The same pin levels hold whenever the block is idle.
- R2: A request is taken only while busy_o is 0. A request raised while a cycle is running is ignored and produces no extra strobe and no extra done pulse. busy_o stays high from the clock after acceptance through the done cycle.
- R3: For exactly T_ADDR_SETUP clocks after acceptance, mem_addr_o shows the accepted address while the strobe, both selects and both byte enables stay high and the data bus is not driven.
- R4: mem_we_n_o, the chosen select and the chosen byte enables fall in the same clock. With the output-enable level high (oe_low_i = 0 at acceptance), the strobe stays low for max(T_PULSE, T_DATA_SETUP) clocks.
- R5: With oe_low_i = 1 at acceptance, mem_oe_n_o is 0 during the cycle and the strobe stays low for max(T_PULSE, T_OUT_OFF + T_DATA_SETUP) clocks.
- R6: Skip-mask bit 1 set keeps mem_ub_n_o high, and bit 0 set keeps mem_lb_n_o high. A clear bit lets that enable fall with the strobe.
- R7: With req_sem_i = 0, mem_ce_n_o is strobed and mem_sem_n_o stays high. With req_sem_i = 1, the reverse holds. The two are never low together.
- R8: After the strobe rises, mem_dq_en_o stays 1 and the address and data stay unchanged for max(T_DATA_HOLD, T_ADDR_HOLD) clocks before the done cycle.
- R9: mem_dq_en_o is 1 only in the clocks where the strobe is low and in the hold clocks that follow. It rises in the same clock in which the strobe falls.
- R10: A skip mask of 2'b11 completes with done_o high in the clock right after acceptance, and no strobe, select or byte enable is ever asserted.
- R11: done_o is high for exactly one clock per accepted request.
- R12: mem_addr_o and mem_dq_o keep the accepted values for the whole cycle, even if the request inputs change while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Write request, taken when idle |
| req_addr_i | input | ADDR_W | Write address |
| req_data_i | input | 2*BYTE_W | Write data, upper byte in the high half |
| req_skip_i | input | 2 | Byte skip mask: bit 1 upper, bit 0 lower, 1 = do not write |
| req_sem_i | input | 1 | 1 = semaphore space, 0 = memory array |
| oe_low_i | input | 1 | 1 = hold memory output enable asserted (low) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_sem_n_o | output | 1 | Semaphore select, active low |
| mem_we_n_o | output | 1 | Read/write strobe, low = write |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_ub_n_o | output | 1 | Upper byte enable, active low |
| mem_lb_n_o | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 2*BYTE_W | Data toward the memory bus |
| mem_dq_en_o | output | 1 | Drive enable for the data bus |

## Verification
The bench measures the length of every phase at the pins and compares it against lengths worked out from the parameters. It uses both output-enable levels, so a design that ignores the turn-off term would leave a five-clock pulse at four clocks. It checks that the data driver turns on in the same clock as the strobe and not earlier. A driver that leads the strobe would clash with memory outputs that are still active, and one that stops at the strobe's rising edge would break the data hold. A request raised mid-cycle with a different address would show up as a second completion or a moved address if the design accepted it outside IDLE. A fully skipped mask would show a stray strobe if the design did not bypass the timed phases.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ADDR_SETUP = 3'd1,
        ST_STROBE     = 3'd2,
        ST_HOLD       = 3'd3,
        ST_DONE       = 3'd4
    } wr_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int AS_LEN    = 2,
    parameter int PULSE_HI  = 4,
    parameter int PULSE_LO  = 5,
    parameter int HOLD_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             skip_all_i,
    input  logic             oe_low_i,
    input  logic             expired_i,
    output wr_state_e        state_o,
    output logic             accept_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o
);

    localparam logic [CNT_W-1:0] AS_LOAD    = CNT_W'(AS_LEN - 1);
    localparam logic [CNT_W-1:0] PHI_LOAD   = CNT_W'(PULSE_HI - 1);
    localparam logic [CNT_W-1:0] PLO_LOAD   = CNT_W'(PULSE_LO - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_LEN - 1);

    wr_state_e state_q;
    wr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = skip_all_i ? ST_DONE : ST_ADDR_SETUP;
                end
            end
            ST_ADDR_SETUP: begin
                if (expired_i) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (expired_i) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (expired_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        accept_o   = (state_q == ST_IDLE) && req_i;
        load_o     = (state_d != state_q);
        load_val_o = '0;
        unique case (state_d)
            ST_ADDR_SETUP: load_val_o = AS_LOAD;
            ST_STROBE:     load_val_o = oe_low_i ? PLO_LOAD : PHI_LOAD;
            ST_HOLD:       load_val_o = HOLD_LOAD;
            ST_IDLE,
            ST_DONE:       load_val_o = '0;
            default:       load_val_o = '0;
        endcase
    end

    assign state_o = state_q;

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  wr_state_e           state_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [2*BYTE_W-1:0] req_data_i,
    input  logic [1:0]          req_skip_i,
    input  logic                req_sem_i,
    input  logic                oe_low_i,
    output logic                skip_all_o,
    output logic                oe_low_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_ce_n_o,
    output logic                mem_sem_n_o,
    output logic                mem_we_n_o,
    output logic                mem_oe_n_o,
    output logic                mem_ub_n_o,
    output logic                mem_lb_n_o,
    output logic [2*BYTE_W-1:0] mem_dq_o,
    output logic                mem_dq_en_o
);

    logic [ADDR_W-1:0]   addr_q;
    logic [2*BYTE_W-1:0] data_q;
    logic [1:0]          skip_q;
    logic                sem_q;
    logic                oe_q;
    logic                strobe_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            skip_q <= 2'b11;
            sem_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (accept_i) begin
                addr_q <= req_addr_i;
                data_q <= req_data_i;
                skip_q <= req_skip_i;
                sem_q  <= req_sem_i;
            end
            if (state_i == ST_IDLE) begin
                oe_q <= oe_low_i;
            end
        end
    end

    always_comb begin
        strobe_on   = (state_i == ST_STROBE);
        mem_we_n_o  = !strobe_on;
        mem_ce_n_o  = !(strobe_on && !sem_q);
        mem_sem_n_o = !(strobe_on && sem_q);
        mem_ub_n_o  = !(strobe_on && !skip_q[1]);
        mem_lb_n_o  = !(strobe_on && !skip_q[0]);
        mem_dq_en_o = (state_i == ST_STROBE) || (state_i == ST_HOLD);
        busy_o      = (state_i != ST_IDLE);
        done_o      = (state_i == ST_DONE);
        mem_oe_n_o  = !oe_q;
        mem_addr_o  = addr_q;
        mem_dq_o    = data_q;
        skip_all_o  = (req_skip_i == 2'b11);
        oe_low_o    = oe_q;
    end

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (mem_dq_en_o && $stable(addr_q) && $stable(data_q)));

    // R5
    oe_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_STROBE) |-> $stable(oe_q));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BYTE_W       = 8,
    parameter int T_ADDR_SETUP = 2,
    parameter int T_PULSE      = 4,
    parameter int T_OUT_OFF    = 3,
    parameter int T_DATA_SETUP = 2,
    parameter int T_DATA_HOLD  = 1,
    parameter int T_ADDR_HOLD  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [2*BYTE_W-1:0] req_data_i,
    input  logic [1:0]          req_skip_i,
    input  logic                req_sem_i,
    input  logic                oe_low_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic                mem_ce_n_o,
    output logic                mem_sem_n_o,
    output logic                mem_we_n_o,
    output logic                mem_oe_n_o,
    output logic                mem_ub_n_o,
    output logic                mem_lb_n_o,
    output logic [2*BYTE_W-1:0] mem_dq_o,
    output logic                mem_dq_en_o
);

    localparam int PULSE_HI = int'(max_u(T_PULSE, T_DATA_SETUP));
    localparam int PULSE_LO = int'(max_u(T_PULSE, T_OUT_OFF + T_DATA_SETUP));
    localparam int HOLD_LEN = int'(max_u(T_DATA_HOLD, T_ADDR_HOLD));
    localparam int MAX_LEN  = int'(max_u(max_u(T_ADDR_SETUP, PULSE_LO),
                                         max_u(PULSE_HI, HOLD_LEN)));
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    wr_state_e        state;
    logic             accept;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             skip_all;
    logic             oe_latched;

    sram_wr_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    sram_wr_fsm #(
        .CNT_W    (CNT_W),
        .AS_LEN   (T_ADDR_SETUP),
        .PULSE_HI (PULSE_HI),
        .PULSE_LO (PULSE_LO),
        .HOLD_LEN (HOLD_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .skip_all_i (skip_all),
        .oe_low_i   (oe_latched),
        .expired_i  (expired),
        .state_o    (state),
        .accept_o   (accept),
        .load_o     (load),
        .load_val_o (load_val)
    );

    sram_wr_pins #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .state_i     (state),
        .req_addr_i  (req_addr_i),
        .req_data_i  (req_data_i),
        .req_skip_i  (req_skip_i),
        .req_sem_i   (req_sem_i),
        .oe_low_i    (oe_low_i),
        .skip_all_o  (skip_all),
        .oe_low_o    (oe_latched),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ce_n_o  (mem_ce_n_o),
        .mem_sem_n_o (mem_sem_n_o),
        .mem_we_n_o  (mem_we_n_o),
        .mem_oe_n_o  (mem_oe_n_o),
        .mem_ub_n_o  (mem_ub_n_o),
        .mem_lb_n_o  (mem_lb_n_o),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_en_o (mem_dq_en_o)
    );

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> $stable(mem_addr_o));

    // R4
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> ((!mem_ce_n_o || !mem_sem_n_o) && (!mem_ub_n_o || !mem_lb_n_o)));

    // R7
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n_o || mem_sem_n_o));

    // R9
    drive_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> (mem_dq_en_o && !$past(mem_dq_en_o)));

    // R9
    no_idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || done_o) |-> !mem_dq_en_o);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R10
    skip_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && skip_all) |=> (done_o && mem_we_n_o && mem_ce_n_o && mem_sem_n_o));

    // R12
    addr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

endmodule

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;

    localparam int AW   = 16;
    localparam int BW   = 8;
    localparam int TAS  = 2;
    localparam int TPW  = 4;
    localparam int TOFF = 3;
    localparam int TDS  = 2;
    localparam int TDH  = 1;
    localparam int TAH  = 2;

    localparam int EXP_P_HI = (TPW > TDS) ? TPW : TDS;
    localparam int EXP_P_LO = (TPW > TOFF + TDS) ? TPW : TOFF + TDS;
    localparam int EXP_HOLD = (TDH > TAH) ? TDH : TAH;

    typedef struct {
        logic [AW-1:0]   addr;
        logic [2*BW-1:0] data;
        logic [1:0]      skip;
        logic            sem;
        logic            oe_low;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [2*BW-1:0] req_data = '0;
    logic [1:0]      req_skip = 2'b00;
    logic            req_sem = 1'b0;
    logic            oe_low = 1'b0;
    logic            busy, done;
    logic [AW-1:0]   mem_addr;
    logic            ce_n, sem_n, we_n, oe_n, ub_n, lb_n;
    logic [2*BW-1:0] dq;
    logic            dq_en;

    always #4 clk = ~clk;

    sram_wr_seq #(
        .ADDR_W(AW), .BYTE_W(BW), .T_ADDR_SETUP(TAS), .T_PULSE(TPW),
        .T_OUT_OFF(TOFF), .T_DATA_SETUP(TDS), .T_DATA_HOLD(TDH), .T_ADDR_HOLD(TAH)
    ) u_sram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .req_data_i(req_data), .req_skip_i(req_skip), .req_sem_i(req_sem),
        .oe_low_i(oe_low), .busy_o(busy), .done_o(done), .mem_addr_o(mem_addr),
        .mem_ce_n_o(ce_n), .mem_sem_n_o(sem_n), .mem_we_n_o(we_n),
        .mem_oe_n_o(oe_n), .mem_ub_n_o(ub_n), .mem_lb_n_o(lb_n),
        .mem_dq_o(dq), .mem_dq_en_o(dq_en)
    );

    int checks = 0;
    int fails = 0;
    int pushed = 0;
    int completed = 0;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor state
    int   setup_n = 0;
    int   pulse_n = 0;
    int   hold_n  = 0;
    logic prev_done = 1'b0;
    logic cap_ce, cap_sem, cap_ub, cap_lb, cap_oe;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk(prev_done == 1'b0, "R11 done longer than one clock", prev_done, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 completion without accepted request", 1, 0);
                end else begin
                    exp_t e;
                    int ep;
                    bit all_skip;
                    e = exp_q.pop_front();
                    all_skip = (e.skip == 2'b11);
                    ep = all_skip ? 0 : (e.oe_low ? EXP_P_LO : EXP_P_HI);
                    completed++;
                    chk(setup_n == (all_skip ? 0 : TAS), "R3 address setup clocks", setup_n, all_skip ? 0 : TAS);
                    if (e.oe_low)
                        chk(pulse_n == ep, "R5 pulse clocks with OE low", pulse_n, ep);
                    else
                        chk(pulse_n == ep, "R4 pulse clocks with OE high", pulse_n, ep);
                    chk(hold_n == (all_skip ? 0 : EXP_HOLD), "R8 hold clocks", hold_n, all_skip ? 0 : EXP_HOLD);
                    if (all_skip) begin
                        chk(pulse_n == 0, "R10 strobe on fully skipped request", pulse_n, 0);
                    end else begin
                        chk(cap_ub == e.skip[1], "R6 upper byte enable", cap_ub, e.skip[1]);
                        chk(cap_lb == e.skip[0], "R6 lower byte enable", cap_lb, e.skip[0]);
                        chk(cap_ce == e.sem, "R7 chip enable level", cap_ce, e.sem);
                        chk(cap_sem == !e.sem, "R7 semaphore select level", cap_sem, !e.sem);
                        chk(cap_oe == !e.oe_low, "R5 memory OE level", cap_oe, !e.oe_low);
                    end
                end
                setup_n = 0;
                pulse_n = 0;
                hold_n  = 0;
            end else if (busy) begin
                if (!we_n) begin
                    if (pulse_n == 0) begin
                        cap_ce = ce_n; cap_sem = sem_n; cap_ub = ub_n; cap_lb = lb_n; cap_oe = oe_n;
                    end
                    pulse_n++;
                    chk(dq_en == 1'b1, "R9 bus not driven during strobe", dq_en, 1);
                    if (exp_q.size() != 0) begin
                        chk(mem_addr == exp_q[0].addr, "R12 address during strobe", mem_addr, exp_q[0].addr);
                        chk(dq == exp_q[0].data, "R12 data during strobe", dq, exp_q[0].data);
                    end
                end else if (dq_en) begin
                    hold_n++;
                    chk(pulse_n > 0, "R9 bus driven before strobe", pulse_n, 1);
                    if (exp_q.size() != 0) begin
                        chk(mem_addr == exp_q[0].addr, "R8 address during hold", mem_addr, exp_q[0].addr);
                        chk(dq == exp_q[0].data, "R8 data during hold", dq, exp_q[0].data);
                    end
                end else begin
                    setup_n++;
                    chk(pulse_n == 0, "R8 drive dropped before done", pulse_n, 0);
                    chk(ce_n && sem_n && ub_n && lb_n, "R3 enable low during setup", 0, 1);
                    if (exp_q.size() != 0)
                        chk(mem_addr == exp_q[0].addr, "R3 address during setup", mem_addr, exp_q[0].addr);
                end
            end else begin
                chk(we_n && ce_n && sem_n && ub_n && lb_n && !dq_en, "R1 idle pin levels", 0, 1);
            end
            prev_done = done;
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [2*BW-1:0] d,
                            input logic [1:0] s, input logic sm, input logic ol,
                            input bit poke);
        exp_t e;
        @(negedge clk);
        oe_low   = ol;
        req_addr = a;
        req_data = d;
        req_skip = s;
        req_sem  = sm;
        req      = 1'b1;
        e.addr = a; e.data = d; e.skip = s; e.sem = sm; e.oe_low = ol;
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
        req      = 1'b0;
        req_addr = ~a;
        req_data = ~d;
        oe_low   = ~ol;
        if (poke && busy) begin
            @(negedge clk);
            req = 1'b1;
            req_skip = 2'b00;
            repeat (3) @(negedge clk);
            req = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R2 watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        chk(we_n && ce_n && sem_n && ub_n && lb_n, "R1 strobes after reset", {we_n, ce_n, sem_n, ub_n, lb_n}, 31);
        chk(!dq_en, "R1 bus drive after reset", dq_en, 0);

        do_write(16'h1234, 16'hA5C3, 2'b00, 1'b0, 1'b0, 1'b0); // R4 both bytes, OE high
        do_write(16'h00F0, 16'h5A3C, 2'b00, 1'b0, 1'b1, 1'b0); // R5 OE low stretches pulse
        do_write(16'h7777, 16'hFFEE, 2'b01, 1'b1, 1'b0, 1'b0); // R6 upper only, R7 semaphore
        do_write(16'h8001, 16'h0102, 2'b10, 1'b0, 1'b1, 1'b0); // R6 lower only
        do_write(16'h4444, 16'h9999, 2'b11, 1'b0, 1'b0, 1'b0); // R10 nothing selected
        do_write(16'hBEEF, 16'hCAFE, 2'b00, 1'b1, 1'b1, 1'b1); // R2 request while busy
        do_write(16'h0001, 16'h1111, 2'b11, 1'b1, 1'b1, 1'b0); // R10 with semaphore
        do_write(16'hFFFF, 16'h8000, 2'b00, 1'b0, 1'b0, 1'b1); // R12 inputs change mid-cycle
        do_write(16'h0002, 16'h0003, 2'b01, 1'b0, 1'b1, 1'b0); // back to back

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 pending expected writes", exp_q.size(), 0);
        chk(completed == pushed, "R11 completions per request", completed, pushed);
        chk(!busy && !dq_en, "R1 idle at end", {busy, dq_en}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule